// File: doc/BRIEF.md
# Key-Protected Device Enable Registers

This block is a small memory-mapped register file that switches peripherals on and off at system level. Software reaches it over a simple single-cycle read/write bus. Two control words hold packed per-device enable fields. Each device has an ID, and a range of like devices shares one field width and one pair of on/off codes. A write to either control word is honoured only while that word's protection is open.

Control word 0 sits behind a timed lock. A correct key written to the lock register opens a short write window, and the lock closes again by itself when the window runs out. Control word 1 sits behind a pair of kick registers, and both must hold their own keys at the same moment. Some ranges are enable-only: once a field holds its enable code, a write cannot move it away. A status word reports, per device, whether the field holds its enable code. The report comes through a fixed delay that stands in for the peripheral acknowledging the change, so software can poll for completion.

Top module: `kdc_regs`

## Requirements
- R1: After reset, control word 0 reads 0x000012AA, control word 1 reads 0x00055550 (every field at its disable code), the lock and both kick flags read 0, the fault flag is 0 and the status word and `dev_state` are 0.
- R2: The word addresses are 0 (control word 0), 1 (control word 1), 2 (lock), 3 (kick A), 4 (kick B) and 5 (status). Reads are allowed at any time whatever the protection state. `rdata` is registered: it updates on the edge that samples `rd_en` and holds its value while `rd_en` is low.
- R3: Writing LOCK_KEY (default 0x5A3C96E1) to the lock opens it. A write to control word 0 is accepted on any of the WINDOW (default 4) edges that follow the key write, and is dropped on any later edge.
- R4: Writing any value other than LOCK_KEY to the lock, including zero, closes it at once. Reading the lock returns the open state in bit 0.
- R5: Every write to a control word that its protection rejects sets a sticky fault flag, read as bit 1 of the lock register. The flag stays set until reset.
- R6: A write to control word 1 is accepted only while kick A holds KICK0_KEY (default 0x2B7D4C18) and kick B holds KICK1_KEY (default 0xC4E07A93). Writing any other value to a kick register clears it. Reading a kick register returns 1 in bit 0 when it holds its key.
- R7: Device ID d of a range lies at bit shift + nbits×(d − first). The ranges (first ID, count, word, shift, nbits, enable, disable, enable-only) are: (0, 4, 0, 0, 2, 1, 2, no), (4, 2, 0, 8, 3, 5, 2, yes), (6, 4, 1, 4, 4, 10, 5, no) and (10, 2, 1, 20, 1, 1, 0, yes). An accepted write stores each field as written.
- R8: In an enable-only range, a field that holds its enable code keeps it through any accepted write.
- R9: Bits of a control word that belong to no device field always read 0.
- R10: Status bit d (status word and `dev_state`) is 1 exactly when device d's field equals its enable code. It follows the control word STAT_LAT (default 3) cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| dev_ctl | output | 64 | Control words; word 0 in bits 31:0 |
| dev_state | output | 12 | Delayed per-device enabled status |

## Verification
The hardest situation to reach is the edge of the timed window. A data write must land exactly WINDOW edges after the key write, and then one edge later. The bench sweeps the gap between the key write and the data write from one to six cycles, counting idle bus cycles, and expects acceptance to stop at the exact boundary. The fault flag must stay clear until the first write outside the window. A second hard case is an enable-only field that is already on. Every device is driven on and then off, and the bench predicts whether the off write sticks and the exact cycle in which the status bit follows.

// File: rtl/kdc_pkg.sv
package kdc_pkg;

  localparam int DW         = 32;
  localparam int AW         = 3;
  localparam int NUM_CTL    = 2;
  localparam int NUM_RANGES = 4;
  localparam int NUM_DEV    = 12;

  typedef enum logic [AW-1:0] {
    A_CTL0  = 3'd0,
    A_CTL1  = 3'd1,
    A_LOCK  = 3'd2,
    A_KICK0 = 3'd3,
    A_KICK1 = 3'd4,
    A_STAT  = 3'd5
  } kdc_addr_e;

  // Range layout table: one entry per group of like device fields.
  localparam int R_FIRST [NUM_RANGES] = '{0, 4, 6, 10};
  localparam int R_COUNT [NUM_RANGES] = '{4, 2, 4, 2};
  localparam int R_WORD  [NUM_RANGES] = '{0, 0, 1, 1};
  localparam int R_SHIFT [NUM_RANGES] = '{0, 8, 4, 20};
  localparam int R_NBITS [NUM_RANGES] = '{2, 3, 4, 1};
  localparam int R_ON    [NUM_RANGES] = '{1, 5, 10, 1};
  localparam int R_OFF   [NUM_RANGES] = '{2, 2, 5, 0};
  localparam int R_ONCE  [NUM_RANGES] = '{0, 1, 0, 1};

  function automatic int range_of(input int id);
    int r;
    r = 0;
    for (int k = 0; k < NUM_RANGES; k++)
      if (id >= R_FIRST[k] && id < R_FIRST[k] + R_COUNT[k]) r = k;
    return r;
  endfunction

  function automatic int dev_word(input int id);
    return R_WORD[range_of(id)];
  endfunction

  function automatic int dev_pos(input int id);
    int r;
    r = range_of(id);
    return R_SHIFT[r] + R_NBITS[r] * (id - R_FIRST[r]);
  endfunction

  function automatic logic dev_once(input int id);
    return R_ONCE[range_of(id)] != 0;
  endfunction

  function automatic logic [DW-1:0] dev_mask(input int id);
    logic [DW-1:0] ones;
    ones = (DW'(1) << R_NBITS[range_of(id)]) - DW'(1);
    return ones << dev_pos(id);
  endfunction

  function automatic logic [DW-1:0] on_word(input int id);
    return DW'(R_ON[range_of(id)]) << dev_pos(id);
  endfunction

  function automatic logic [DW-1:0] off_word(input int id);
    return DW'(R_OFF[range_of(id)]) << dev_pos(id);
  endfunction

  function automatic logic [DW-1:0] reset_word(input int w);
    logic [DW-1:0] acc;
    acc = '0;
    for (int d = 0; d < NUM_DEV; d++)
      if (dev_word(d) == w) acc = acc | off_word(d);
    return acc;
  endfunction

endpackage

// File: rtl/kdc_timed_lock.sv
module kdc_timed_lock #(
  parameter int              DW     = 32,
  parameter int              WINDOW = 4,
  parameter logic [DW-1:0]   KEY    = 32'h5A3C_96E1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output logic          open
);

  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (key_wr) begin
      left_q <= (key_data == KEY) ? CW'(WINDOW) : '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign open = (left_q != '0);

endmodule

// File: rtl/kdc_kick_pair.sv
module kdc_kick_pair #(
  parameter int            DW   = 32,
  parameter logic [DW-1:0] KEY0 = 32'h2B7D_4C18,
  parameter logic [DW-1:0] KEY1 = 32'hC4E0_7A93
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr0,
  input  logic          wr1,
  input  logic [DW-1:0] data,
  output logic          ok0,
  output logic          ok1,
  output logic          unlocked
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ok0 <= 1'b0;
      ok1 <= 1'b0;
    end else begin
      if (wr0) ok0 <= (data == KEY0);
      if (wr1) ok1 <= (data == KEY1);
    end
  end

  assign unlocked = ok0 & ok1;

endmodule

// File: rtl/kdc_field_merge.sv
module kdc_field_merge
  import kdc_pkg::*;
#(
  parameter int WORD_IDX = 0
) (
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] new_word,
  output logic [DW-1:0] merged
);

  logic [DW-1:0] part [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    if (dev_word(d) == WORD_IDX) begin : g_own
      localparam logic [DW-1:0] MASK = dev_mask(d);
      localparam logic [DW-1:0] ON_W = on_word(d);
      localparam logic          ONCE = dev_once(d);
      logic held;
      assign held    = ONCE && ((old_word & MASK) == ON_W);
      assign part[d] = held ? (old_word & MASK) : (new_word & MASK);
    end else begin : g_other
      assign part[d] = '0;
    end
  end

  always_comb begin
    merged = '0;
    for (int d = 0; d < NUM_DEV; d++) merged = merged | part[d];
  end

endmodule

// File: rtl/kdc_status_pipe.sv
module kdc_status_pipe #(
  parameter int W   = 12,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[LAT-1];

endmodule

// File: rtl/kdc_regs.sv
module kdc_regs
  import kdc_pkg::*;
#(
  parameter int            WINDOW    = 4,
  parameter int            STAT_LAT  = 3,
  parameter logic [DW-1:0] LOCK_KEY  = 32'h5A3C_96E1,
  parameter logic [DW-1:0] KICK0_KEY = 32'h2B7D_4C18,
  parameter logic [DW-1:0] KICK1_KEY = 32'hC4E0_7A93
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic [NUM_CTL*DW-1:0] dev_ctl,
  output logic [NUM_DEV-1:0]    dev_state
);

  logic               lock_open;
  logic               kick_ok;
  logic               kick_a;
  logic               kick_b;
  logic               fault_q;
  logic [NUM_CTL-1:0] may_wr;
  logic               reject;
  logic [NUM_DEV-1:0] dev_on;

  kdc_timed_lock #(.DW(DW), .WINDOW(WINDOW), .KEY(LOCK_KEY)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_en && addr == A_LOCK),
    .key_data (wdata),
    .open     (lock_open)
  );

  kdc_kick_pair #(.DW(DW), .KEY0(KICK0_KEY), .KEY1(KICK1_KEY)) u_kick (
    .clk      (clk),
    .rst      (rst),
    .wr0      (wr_en && addr == A_KICK0),
    .wr1      (wr_en && addr == A_KICK1),
    .data     (wdata),
    .ok0      (kick_a),
    .ok1      (kick_b),
    .unlocked (kick_ok)
  );

  assign may_wr = {kick_ok, lock_open};

  for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
    logic [DW-1:0] word_q;
    logic [DW-1:0] merged;

    kdc_field_merge #(.WORD_IDX(c)) u_merge (
      .old_word (word_q),
      .new_word (wdata),
      .merged   (merged)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= reset_word(c);
      end else if (wr_en && addr == AW'(c) && may_wr[c]) begin
        word_q <= merged;
      end
    end

    assign dev_ctl[c*DW +: DW] = word_q;
  end

  assign reject = wr_en &&
                  ((addr == A_CTL0 && !lock_open) || (addr == A_CTL1 && !kick_ok));

  always_ff @(posedge clk) begin
    if (rst)         fault_q <= 1'b0;
    else if (reject) fault_q <= 1'b1;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_on
    localparam int            WI   = dev_word(d);
    localparam logic [DW-1:0] MASK = dev_mask(d);
    localparam logic [DW-1:0] ON_W = on_word(d);
    assign dev_on[d] = (dev_ctl[WI*DW +: DW] & MASK) == ON_W;
  end

  kdc_status_pipe #(.W(NUM_DEV), .LAT(STAT_LAT)) u_stat (
    .clk  (clk),
    .rst  (rst),
    .din  (dev_on),
    .dout (dev_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_CTL0:  rdata <= dev_ctl[0 +: DW];
        A_CTL1:  rdata <= dev_ctl[DW +: DW];
        A_LOCK:  rdata <= DW'({fault_q, lock_open});
        A_KICK0: rdata <= DW'(kick_a);
        A_KICK1: rdata <= DW'(kick_b);
        A_STAT:  rdata <= DW'(dev_state);
        default: rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/kdc_regs_chk.sv
module kdc_regs_chk
  import kdc_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [AW-1:0]         addr,
  input logic [DW-1:0]         wdata,
  input logic [DW-1:0]         rdata,
  input logic [NUM_CTL*DW-1:0] dev_ctl,
  input logic                  lock_open,
  input logic                  kick_ok,
  input logic                  fault
);

  logic [DW-1:0] w0;
  logic [DW-1:0] w1;
  int            since_key;

  assign w0 = dev_ctl[0 +: DW];
  assign w1 = dev_ctl[DW +: DW];

  always_ff @(posedge clk) begin
    if (rst)                              since_key <= WINDOW + 1;
    else if (wr_en && addr == A_LOCK)     since_key <= 0;
    else if (since_key <= WINDOW)         since_key <= since_key + 1;
  end

  p_read_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  p_locked_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTL0 && !lock_open) |=> $stable(w0));

  p_window_len_r3: assert property (@(posedge clk) disable iff (rst)
    lock_open |-> since_key < WINDOW);

  p_zero_relock_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_LOCK && wdata == '0) |=> !lock_open);

  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  p_kick_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTL1 && !kick_ok) |=> $stable(w1));

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_once
    if (dev_once(d)) begin : g_chk
      localparam int            WI   = dev_word(d);
      localparam logic [DW-1:0] MASK = dev_mask(d);
      localparam logic [DW-1:0] ON_W = on_word(d);
      p_once_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ((dev_ctl[WI*DW +: DW] & MASK) == ON_W) |=> ((dev_ctl[WI*DW +: DW] & MASK) == ON_W));
    end
  end

endmodule

bind kdc_regs kdc_regs_chk #(.WINDOW(WINDOW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .dev_ctl   (dev_ctl),
  .lock_open (lock_open),
  .kick_ok   (kick_ok),
  .fault     (fault_q)
);

// File: tb/kdc_regs_test.sv
`timescale 1ns/1ps
module kdc_regs_test;

  localparam int          SL   = 3;
  localparam int          WIN  = 4;
  localparam logic [31:0] LKEY = 32'h5A3C_96E1;
  localparam logic [31:0] KA   = 32'h2B7D_4C18;
  localparam logic [31:0] KB   = 32'hC4E0_7A93;
  localparam logic [2:0]  AD_C0 = 3'd0, AD_C1 = 3'd1, AD_LK = 3'd2,
                          AD_KA = 3'd3, AD_KB = 3'd4, AD_ST = 3'd5;

  localparam int T_FIRST [4] = '{0, 4, 6, 10};
  localparam int T_COUNT [4] = '{4, 2, 4, 2};
  localparam int T_WORD  [4] = '{0, 0, 1, 1};
  localparam int T_SHIFT [4] = '{0, 8, 4, 20};
  localparam int T_NBITS [4] = '{2, 3, 4, 1};
  localparam int T_ON    [4] = '{1, 5, 10, 1};
  localparam int T_OFF   [4] = '{2, 2, 5, 0};
  localparam int T_ONCE  [4] = '{0, 1, 0, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] dev_ctl;
  logic [11:0] dev_state;

  int          checks = 0;
  int          errors = 0;
  logic [31:0] m [2];

  always #2.5 clk = ~clk;

  kdc_regs #(.WINDOW(WIN), .STAT_LAT(SL), .LOCK_KEY(LKEY),
             .KICK0_KEY(KA), .KICK1_KEY(KB)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dev_ctl(dev_ctl), .dev_state(dev_state));

  function automatic int rg(input int id);
    int r;
    r = 0;
    for (int k = 0; k < 4; k++)
      if (id >= T_FIRST[k] && id < T_FIRST[k] + T_COUNT[k]) r = k;
    return r;
  endfunction

  function automatic int pos(input int id);
    return T_SHIFT[rg(id)] + T_NBITS[rg(id)] * (id - T_FIRST[rg(id)]);
  endfunction

  function automatic logic [31:0] fmask(input int id);
    return ((32'd1 << T_NBITS[rg(id)]) - 32'd1) << pos(id);
  endfunction

  function automatic logic [31:0] onw(input int id);
    return 32'(T_ON[rg(id)]) << pos(id);
  endfunction

  function automatic logic [31:0] offw(input int id);
    return 32'(T_OFF[rg(id)]) << pos(id);
  endfunction

  function automatic logic [31:0] expect_write(input int w, input logic [31:0] old, input logic [31:0] nw);
    logic [31:0] r;
    r = '0;
    for (int d = 0; d < 12; d++) begin
      if (T_WORD[rg(d)] == w) begin
        if (T_ONCE[rg(d)] != 0 && (old & fmask(d)) == onw(d)) r = r | (old & fmask(d));
        else                                                  r = r | (nw & fmask(d));
      end
    end
    return r;
  endfunction

  function automatic logic [11:0] expect_stat();
    logic [11:0] s;
    for (int d = 0; d < 12; d++)
      s[d] = (m[T_WORD[rg(d)]] & fmask(d)) == onw(d);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic prot_wr(input int w, input logic [31:0] d);
    if (w == 0) wr(AD_LK, LKEY);
    wr(3'(w), d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] nw;
    logic [11:0] st_old;
    logic        fault_exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m[0] = '0; m[1] = '0;
    for (int d = 0; d < 12; d++) m[T_WORD[rg(d)]] = m[T_WORD[rg(d)]] | offw(d);

    // R1 reset state
    rd(AD_C0, v); chk("R1 ctl0 reset", v, 32'h0000_12AA);
    chk("R1 ctl0 model", m[0], 32'h0000_12AA);
    rd(AD_C1, v); chk("R1 ctl1 reset", v, 32'h0005_5550);
    rd(AD_LK, v); chk("R1 lock", v, 32'h0);
    rd(AD_KA, v); chk("R1 kick a", v, 32'h0);
    rd(AD_KB, v); chk("R1 kick b", v, 32'h0);
    rd(AD_ST, v); chk("R1 status", v, 32'h0);
    chk("R1 dev_state", 32'(dev_state), 32'h0);

    // R3 / R5 window sweep: data write d edges after key write
    for (int d = 1; d <= 6; d++) begin
      nw = 32'h1200 | ((32'(d) * 32'h11) & 32'hFF);
      wr(AD_LK, LKEY);
      repeat (d - 1) @(negedge clk);
      wr(AD_C0, nw);
      if (d <= WIN) m[0] = expect_write(0, m[0], nw);
      wr(AD_LK, 32'h0);
      rd(AD_C0, v); chk($sformatf("R3 window gap %0d", d), v, m[0]);
      rd(AD_LK, v); chk($sformatf("R5 fault after gap %0d", d), v, {30'b0, d > WIN, 1'b0});
    end

    // R4 open bit, zero relock, wrong key
    wr(AD_LK, LKEY);
    rd(AD_LK, v); chk("R4 open after key", v, 32'h3);
    wr(AD_LK, 32'h0);
    rd(AD_LK, v); chk("R4 closed after zero", v, 32'h2);
    wr(AD_C0, 32'h0000_12FF);
    rd(AD_C0, v); chk("R4 write after zero relock", v, m[0]);
    wr(AD_LK, LKEY ^ 32'h1);
    rd(AD_LK, v); chk("R4 wrong key stays closed", v, 32'h2);
    wr(AD_C0, 32'h0000_12FF);
    rd(AD_C0, v); chk("R4 write after wrong key", v, m[0]);
    wr(AD_LK, LKEY);
    wr(AD_LK, LKEY ^ 32'h8000_0000);
    wr(AD_C0, 32'h0000_12FF);
    rd(AD_C0, v); chk("R4 wrong key closes open lock", v, m[0]);

    // R6 kick pair
    wr(AD_KA, KA);
    rd(AD_KA, v); chk("R6 kick a holds key", v, 32'h1);
    wr(AD_C1, 32'h0000_AAA0);
    rd(AD_C1, v); chk("R6 one kick only", v, m[1]);
    wr(AD_KB, KB);
    rd(AD_KB, v); chk("R6 kick b holds key", v, 32'h1);
    wr(AD_C1, 32'h0005_A550);
    m[1] = expect_write(1, m[1], 32'h0005_A550);
    rd(AD_C1, v); chk("R6 both kicks accept", v, m[1]);
    wr(AD_KB, 32'h0);
    rd(AD_KB, v); chk("R6 kick b cleared", v, 32'h0);
    wr(AD_C1, 32'h0005_5550);
    rd(AD_C1, v); chk("R6 write after kick clear", v, m[1]);
    wr(AD_KB, KB);

    // R7 / R8 / R10 sweep of every device: enable then disable
    for (int id = 0; id < 12; id++) begin
      for (int ph = 0; ph < 2; ph++) begin
        int w;
        w = T_WORD[rg(id)];
        st_old = expect_stat();
        nw = (m[w] & ~fmask(id)) | ((ph == 0) ? onw(id) : offw(id));
        prot_wr(w, nw);
        m[w] = expect_write(w, m[w], nw);
        repeat (SL - 1) @(negedge clk);
        chk($sformatf("R10 status before latency id %0d ph %0d", id, ph), 32'(dev_state), 32'(st_old));
        @(negedge clk);
        chk($sformatf("R10 status after latency id %0d ph %0d", id, ph), 32'(dev_state), 32'(expect_stat()));
        rd(3'(w), v);
        if (ph == 1 && T_ONCE[rg(id)] != 0)
          chk($sformatf("R8 enable-only hold id %0d", id), v, m[w]);
        else
          chk($sformatf("R7 field write id %0d ph %0d", id, ph), v, m[w]);
        chk($sformatf("R7 dev_ctl port id %0d", id), dev_ctl[w*32 +: 32], m[w]);
        rd(AD_ST, v); chk($sformatf("R10 status word id %0d", id), v, 32'(expect_stat()));
      end
    end

    // R9 bits outside fields read zero
    prot_wr(0, 32'hFFFF_FFFF);
    m[0] = expect_write(0, m[0], 32'hFFFF_FFFF);
    rd(AD_C0, v); chk("R9 ctl0 unused bits", v, m[0]);
    chk("R9 ctl0 expected value", m[0], 32'h0000_2DFF);
    prot_wr(1, 32'hFFFF_FFFF);
    m[1] = expect_write(1, m[1], 32'hFFFF_FFFF);
    rd(AD_C1, v); chk("R9 ctl1 unused bits", v, 32'h003F_FFF0);

    // R2 rdata holds while no read is issued
    v = rdata;
    fault_exp = 1'b1;
    wr(AD_LK, 32'h0);
    repeat (3) @(negedge clk);
    chk("R2 rdata held", rdata, v);
    rd(AD_LK, v); chk("R5 fault still set", v, {30'b0, fault_exp, 1'b0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule